// File: doc/BRIEF.md
# Masked-Write Banked Control Register File

This block holds the system-control registers of a small multithreaded core. A register is addressed by an 8-bit flat index. The upper five bits are the register number and the lower three bits are the select, so the index equals number*8+select. Every register has a 32-bit value and a 32-bit writable-bit mask. The mask is fixed when the block leaves reset.

Each register lives in several banks. A small group of registers keeps one copy per hardware thread. All other registers keep one copy per processing element. For those, the bank is taken from the element field of the requesting thread's binding register. Hardware uses a raw write port, which stores the whole word. Software uses a filtered write port, which changes only the bits set in the register's mask. A combinational read port returns the value and the mask of the bank that the reading thread sees.

Top module: `cregFile`

## Requirements
- R1: The flat index `idx` selects register number `idx[7:3]` and select `idx[2:0]`. For example, number 12 select 0 is index 96, and number 13 select 0 is index 104.
- R2: After reset every value is zero, with three exceptions. Index 96 (status) holds 0x00400004, with error-level bit 2 and boot-vector bit 22 set. Index 8 (random) holds 63. Index 121 (exception base) holds 0x80000000.
- R3: Each mask is all ones, except for these indices:
  - 0: 0x7FFFFFFF
  - 16 and 24: 0x3FFFFFFF
  - 32: 0xFF800000
  - 40: 0x1FFFF800
  - 96: 0xFF78FF17
  - 97: 0x000003E0
  - 98: 0x0000F3C0
  - 104: 0x08C00300
  - 121: 0x3FFFF000
  - 128: 0x7FFF0007
  - 8, 64, 120, 129, 131 and 136: 0
- R4: A filtered write stores (data AND mask) OR (old value AND NOT mask). The result is visible from the next cycle.
- R5: A filtered write to a register with an all-zero mask leaves its value unchanged.
- R6: A raw write stores the full 32-bit data word, whatever the mask.
- R7: Indices 17 to 23 (number 2, select 1 to 7) are banked per thread. The bank is the requesting thread's number.
- R8: All other indices are banked per element. The bank is bits [ELEM_W-1:0] of the requesting thread's copy of index 18 (the binding register, itself per thread). Binding is 0 after reset, so all threads start on element 0.
- R9: When a raw write and a filtered write hit the same index in the same bank in the same cycle, only the filtered write takes effect. It merges with the value held before that cycle.
- R10: When a raw write and a filtered write target different registers or banks in the same cycle, both take effect.
- R11: Reads are combinational and have no side effects. Re-reading returns the same value while no write occurs.
- R12: Asserting reset again restores every value of R2 and every mask of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawWrEn | input | 1 | Raw (unmasked) write enable |
| rawThread | input | THR_W | Thread issuing the raw write |
| rawIdx | input | 8 | Flat index of the raw write |
| rawData | input | 32 | Raw write data |
| swWrEn | input | 1 | Filtered (masked) write enable |
| swThread | input | THR_W | Thread issuing the filtered write |
| swIdx | input | 8 | Flat index of the filtered write |
| swData | input | 32 | Filtered write data |
| rdThread | input | THR_W | Thread issuing the read |
| rdIdx | input | 8 | Flat index of the read |
| rdData | output | 32 | Value of the selected register and bank |
| rdMask | output | 32 | Writable-bit mask of the selected register |

## Verification
The raw and the filtered write port can both fire in one cycle. When both target the same register and bank, the filtered result must be the only one that lands. The bench raises both enables together on one per-element register, using different data words. It then reads the register back and expects the filtered data merged with the value from before the cycle. A second case sends the two ports to different registers in one cycle and expects both writes to persist.

// File: rtl/cregPkg.sv
package cregPkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 8;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] BIND_IDX = 8'd18;

  typedef struct packed {
    logic rawWe;
    logic swWe;
  } wrStrobe_t;

  function automatic logic [DATA_W-1:0] initMask(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd0:    initMask = 32'h7FFF_FFFF;
      8'd16,
      8'd24:   initMask = 32'h3FFF_FFFF;
      8'd32:   initMask = 32'hFF80_0000;
      8'd40:   initMask = 32'h1FFF_F800;
      8'd96:   initMask = 32'hFF78_FF17;
      8'd97:   initMask = 32'h0000_03E0;
      8'd98:   initMask = 32'h0000_F3C0;
      8'd104:  initMask = 32'h08C0_0300;
      8'd121:  initMask = 32'h3FFF_F000;
      8'd128:  initMask = 32'h7FFF_0007;
      8'd8, 8'd64, 8'd120, 8'd129, 8'd131, 8'd136:
               initMask = 32'h0000_0000;
      default: initMask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] initVal(input logic [IDX_W-1:0] idx);
    case (idx)
      8'd96:   initVal = 32'h0040_0004;
      8'd8:    initVal = 32'd63;
      8'd121:  initVal = 32'h8000_0000;
      default: initVal = '0;
    endcase
  endfunction

  function automatic logic isPerThread(input logic [IDX_W-1:0] idx);
    isPerThread = (idx[7:3] == 5'd2) && (idx[2:0] != 3'd0);
  endfunction
endpackage

// File: rtl/cregCtl.sv
module cregCtl
  import cregPkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int THR_W       = 1,
  parameter int BANK_IW     = 1
) (
  input  logic                   rawWrEn,
  input  logic [THR_W-1:0]       rawThread,
  input  logic [IDX_W-1:0]       rawIdx,
  input  logic                   swWrEn,
  input  logic [THR_W-1:0]       swThread,
  input  logic [IDX_W-1:0]       swIdx,
  input  logic [THR_W-1:0]       rdThread,
  input  logic [IDX_W-1:0]       rdIdx,
  input  logic [BANK_IW-1:0]     elemOfThread [NUM_THREADS],
  output wrStrobe_t              stb,
  output logic [BANK_IW-1:0]     rawBank,
  output logic [BANK_IW-1:0]     swBank,
  output logic [BANK_IW-1:0]     rdBank
);
  logic sameTarget;

  always_comb begin
    rawBank = isPerThread(rawIdx) ? BANK_IW'(rawThread) : elemOfThread[rawThread];
    swBank  = isPerThread(swIdx)  ? BANK_IW'(swThread)  : elemOfThread[swThread];
    rdBank  = isPerThread(rdIdx)  ? BANK_IW'(rdThread)  : elemOfThread[rdThread];
  end

  // filtered write wins on collision: suppress the raw strobe
  assign sameTarget = (rawIdx == swIdx) && (rawBank == swBank);
  assign stb.swWe   = swWrEn;
  assign stb.rawWe  = rawWrEn && !(swWrEn && sameTarget);
endmodule

// File: rtl/cregDp.sv
module cregDp
  import cregPkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ELEM_W      = 1,
  parameter int BANK_IW     = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wrStrobe_t              stb,
  input  logic [BANK_IW-1:0]     rawBank,
  input  logic [IDX_W-1:0]       rawIdx,
  input  logic [DATA_W-1:0]      rawData,
  input  logic [BANK_IW-1:0]     swBank,
  input  logic [IDX_W-1:0]       swIdx,
  input  logic [DATA_W-1:0]      swData,
  input  logic [BANK_IW-1:0]     rdBank,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [DATA_W-1:0]      rdData,
  output logic [DATA_W-1:0]      rdMask,
  output logic [BANK_IW-1:0]     elemOfThread [NUM_THREADS]
);
  localparam int NUM_BANKS = 1 << BANK_IW;

  logic [DATA_W-1:0] store [NUM_BANKS][NUM_REGS];
  logic [DATA_W-1:0] swMask;
  logic [DATA_W-1:0] swMerged;

  assign swMask   = initMask(swIdx);
  assign swMerged = (swData & swMask) | (store[swBank][swIdx] & ~swMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int i = 0; i < NUM_REGS; i++)
          store[b][i] <= initVal(IDX_W'(i));
    end else begin
      if (stb.rawWe) store[rawBank][rawIdx] <= rawData;
      if (stb.swWe)  store[swBank][swIdx]   <= swMerged;
    end
  end

  genvar t;
  generate
    for (t = 0; t < NUM_THREADS; t++) begin : gBind
      assign elemOfThread[t] = BANK_IW'(store[t][BIND_IDX][ELEM_W-1:0]);
    end
  endgenerate

  assign rdData = store[rdBank][rdIdx];
  assign rdMask = initMask(rdIdx);
endmodule

// File: rtl/cregFile.sv
module cregFile
  import cregPkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_ELEMS   = 2,
  localparam int THR_W   = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int ELEM_W  = (NUM_ELEMS > 1) ? $clog2(NUM_ELEMS) : 1,
  localparam int MAXB    = (NUM_THREADS > (1 << ELEM_W)) ? NUM_THREADS : (1 << ELEM_W),
  localparam int BANK_IW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawWrEn,
  input  logic [THR_W-1:0]  rawThread,
  input  logic [7:0]        rawIdx,
  input  logic [31:0]       rawData,
  input  logic              swWrEn,
  input  logic [THR_W-1:0]  swThread,
  input  logic [7:0]        swIdx,
  input  logic [31:0]       swData,
  input  logic [THR_W-1:0]  rdThread,
  input  logic [7:0]        rdIdx,
  output logic [31:0]       rdData,
  output logic [31:0]       rdMask
);
  wrStrobe_t          stb;
  logic [BANK_IW-1:0] rawBank, swBank, rdBank;
  logic [BANK_IW-1:0] elemOfThread [NUM_THREADS];

  cregCtl #(.NUM_THREADS(NUM_THREADS), .THR_W(THR_W), .BANK_IW(BANK_IW)) uCtl (
    .rawWrEn(rawWrEn), .rawThread(rawThread), .rawIdx(rawIdx),
    .swWrEn(swWrEn), .swThread(swThread), .swIdx(swIdx),
    .rdThread(rdThread), .rdIdx(rdIdx), .elemOfThread(elemOfThread),
    .stb(stb), .rawBank(rawBank), .swBank(swBank), .rdBank(rdBank)
  );

  cregDp #(.NUM_THREADS(NUM_THREADS), .ELEM_W(ELEM_W), .BANK_IW(BANK_IW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rawBank(rawBank), .rawIdx(rawIdx), .rawData(rawData),
    .swBank(swBank), .swIdx(swIdx), .swData(swData),
    .rdBank(rdBank), .rdIdx(rdIdx), .rdData(rdData), .rdMask(rdMask),
    .elemOfThread(elemOfThread)
  );
endmodule

// File: rtl/cregFileChk.sv
module cregFileChk #(
  parameter int THR_W = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             rawWrEn,
  input logic [THR_W-1:0] rawThread,
  input logic [7:0]       rawIdx,
  input logic [31:0]      rawData,
  input logic             swWrEn,
  input logic [THR_W-1:0] swThread,
  input logic [7:0]       swIdx,
  input logic [31:0]      swData,
  input logic [THR_W-1:0] rdThread,
  input logic [7:0]       rdIdx,
  input logic [31:0]      rdData,
  input logic [31:0]      rdMask
);
  logic swHitsRd, rawHitsRd, rawTouchesBind;
  assign swHitsRd       = swWrEn && swThread == rdThread && swIdx == rdIdx;
  assign rawHitsRd      = rawWrEn && rawThread == rdThread && rawIdx == rdIdx;
  assign rawTouchesBind = rawWrEn && rawIdx == 8'd18;

  // R4 and R9: filtered write merges with the old value, even against a raw write
  a_r4_filtered_merge: assert property (@(posedge clk) disable iff (!rstN)
    (swHitsRd && !rawTouchesBind) |=>
      ((rdIdx != $past(rdIdx)) || (rdThread != $past(rdThread)) ||
       (rdData == (($past(swData) & $past(rdMask)) | ($past(rdData) & ~$past(rdMask))))));

  // R6: raw write alone stores the whole word
  a_r6_raw_full: assert property (@(posedge clk) disable iff (!rstN)
    (rawHitsRd && !swWrEn) |=>
      ((rdIdx != $past(rdIdx)) || (rdThread != $past(rdThread)) || (rdData == $past(rawData))));

  // R11: with no writes a held read target keeps its value
  a_r11_read_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!rawWrEn && !swWrEn) |=>
      ((rdIdx != $past(rdIdx)) || (rdThread != $past(rdThread)) || $stable(rdData)));

  // R5: read-only register is not changed by a filtered write alone
  a_r5_readonly_kept: assert property (@(posedge clk) disable iff (!rstN)
    (swHitsRd && !rawWrEn && rdMask == 32'h0) |=>
      ((rdIdx != $past(rdIdx)) || (rdThread != $past(rdThread)) || $stable(rdData)));
endmodule

bind cregFile cregFileChk #(.THR_W(THR_W)) uChk (
  .clk(clk), .rstN(rstN), .rawWrEn(rawWrEn), .rawThread(rawThread),
  .rawIdx(rawIdx), .rawData(rawData), .swWrEn(swWrEn), .swThread(swThread),
  .swIdx(swIdx), .swData(swData), .rdThread(rdThread), .rdIdx(rdIdx),
  .rdData(rdData), .rdMask(rdMask)
);

// File: tb/tb_cregFile.sv
`timescale 1ns/1ps
module tb_cregFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rawWrEn = 1'b0, swWrEn = 1'b0;
  logic [0:0]  rawThread = '0, swThread = '0, rdThread = '0;
  logic [7:0]  rawIdx = '0, swIdx = '0, rdIdx = '0;
  logic [31:0] rawData = '0, swData = '0;
  logic [31:0] rdData, rdMask;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cregFile dut (
    .clk(clk), .rstN(rstN),
    .rawWrEn(rawWrEn), .rawThread(rawThread), .rawIdx(rawIdx), .rawData(rawData),
    .swWrEn(swWrEn), .swThread(swThread), .swIdx(swIdx), .swData(swData),
    .rdThread(rdThread), .rdIdx(rdIdx), .rdData(rdData), .rdMask(rdMask)
  );

  task automatic chkVal(input string req, input logic [0:0] thr, input logic [7:0] idx,
                        input logic [31:0] expV);
    rdThread = thr; rdIdx = idx; #1;
    checks++;
    if (rdData !== expV) begin
      fails++;
      $display("FAIL %s: value t%0d idx %0d actual %h expected %h", req, thr, idx, rdData, expV);
    end
  endtask

  task automatic chkMask(input string req, input logic [7:0] idx, input logic [31:0] expM);
    rdThread = '0; rdIdx = idx; #1;
    checks++;
    if (rdMask !== expM) begin
      fails++;
      $display("FAIL %s: mask idx %0d actual %h expected %h", req, idx, rdMask, expM);
    end
  endtask

  task automatic swWrite(input logic [0:0] thr, input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk); swWrEn = 1; swThread = thr; swIdx = idx; swData = d;
    @(negedge clk); swWrEn = 0;
  endtask

  task automatic rawWrite(input logic [0:0] thr, input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk); rawWrEn = 1; rawThread = thr; rawIdx = idx; rawData = d;
    @(negedge clk); rawWrEn = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  task automatic testReset(input string req);
    chkVal(req, 0, {5'd12, 3'd0}, 32'h0040_0004);
    chkVal(req, 1, 8'd8, 32'd63);
    chkVal(req, 0, 8'd121, 32'h8000_0000);
    chkVal(req, 0, 8'd72, 32'h0);
    chkMask(req, {5'd13, 3'd0}, 32'h08C0_0300);
    chkMask(req, 8'd96, 32'hFF78_FF17);
    chkMask(req, 8'd0, 32'h7FFF_FFFF);
    chkMask(req, 8'd121, 32'h3FFF_F000);
    chkMask(req, 8'd136, 32'h0);
    chkMask(req, 8'd72, 32'hFFFF_FFFF);
  endtask

  task automatic testFilter();
    rawWrite(0, 8'd96, 32'hFFFF_FFFF);
    swWrite(0, 8'd96, 32'h0);
    chkVal("R4", 0, 8'd96, 32'h0087_00E8);
    swWrite(0, 8'd104, 32'hFFFF_FFFF);
    chkVal("R4", 0, 8'd104, 32'h08C0_0300);
  endtask

  task automatic testReadOnly();
    swWrite(0, 8'd120, 32'hDEAD_BEEF);
    chkVal("R5", 0, 8'd120, 32'h0);
    swWrite(0, 8'd8, 32'h0);
    chkVal("R5", 0, 8'd8, 32'd63);
  endtask

  task automatic testRaw();
    rawWrite(0, 8'd120, 32'h1234_5678);
    chkVal("R6", 0, 8'd120, 32'h1234_5678);
  endtask

  task automatic testThreadBank();
    swWrite(0, 8'd17, 32'hAAAA_5555);
    swWrite(1, 8'd17, 32'h0000_1234);
    chkVal("R7", 0, 8'd17, 32'hAAAA_5555);
    chkVal("R7", 1, 8'd17, 32'h0000_1234);
  endtask

  task automatic testElemBank();
    swWrite(0, 8'd72, 32'h11);
    chkVal("R8", 1, 8'd72, 32'h11);
    swWrite(1, 8'd18, 32'h1);
    chkVal("R8", 0, 8'd18, 32'h0);
    chkVal("R8", 1, 8'd72, 32'h0);
    swWrite(1, 8'd72, 32'h22);
    chkVal("R8", 0, 8'd72, 32'h11);
    chkVal("R8", 1, 8'd72, 32'h22);
  endtask

  task automatic testConflict();
    @(negedge clk);
    rawWrEn = 1; rawThread = 0; rawIdx = 8'd72; rawData = 32'hCAFE;
    swWrEn  = 1; swThread  = 0; swIdx  = 8'd72; swData  = 32'hBEEF;
    @(negedge clk); rawWrEn = 0; swWrEn = 0;
    chkVal("R9", 0, 8'd72, 32'hBEEF);
    @(negedge clk);
    rawWrEn = 1; rawThread = 0; rawIdx = 8'd120; rawData = 32'h5555_0000;
    swWrEn  = 1; swThread  = 0; swIdx  = 8'd120; swData  = 32'hFFFF_FFFF;
    @(negedge clk); rawWrEn = 0; swWrEn = 0;
    chkVal("R9", 0, 8'd120, 32'h1234_5678);
  endtask

  task automatic testDual();
    @(negedge clk);
    rawWrEn = 1; rawThread = 0; rawIdx = 8'd73; rawData = 32'h5;
    swWrEn  = 1; swThread  = 0; swIdx  = 8'd74; swData  = 32'h6;
    @(negedge clk); rawWrEn = 0; swWrEn = 0;
    chkVal("R10", 0, 8'd73, 32'h5);
    chkVal("R10", 0, 8'd74, 32'h6);
  endtask

  task automatic testReadSide();
    chkVal("R11", 0, 8'd8, 32'd63);
    @(negedge clk);
    chkVal("R11", 0, 8'd8, 32'd63);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset("R2 R3 R1");
    testFilter();
    testReadOnly();
    testRaw();
    testThreadBank();
    testElemBank();
    testConflict();
    testDual();
    testReadSide();
    doReset();
    testReset("R12");
    chkVal("R12", 1, 8'd72, 32'h0);
    finishRun();
  end
endmodule